// File: doc/BRIEF.md
# Fence and I/O ordering gate

This block sits between an in-order access-issue stage and an interconnect that may complete requests in any order. Each translated access arrives with its region attribute (device region or main memory), its ordering channel and a device number. The gate sorts the access into one of four ordering classes and keeps a count of the requests of each class that are still in flight. It holds back an access whenever an ordering rule says that earlier work must finish first. The rules come from fence instructions, from strongly ordered device channels, and from a per-page override that the second translation stage supplies.

When virtualization mode is on, the override turns a guest page into a device region for ordering purposes. The access is then sent with acquire-plus-release ordering: it waits until nothing is in flight, and nothing after it issues until it completes. The upstream stage marks whether it already expected such an access. If it did not, the override was discovered too late. The gate then consumes the request, forwards nothing and raises a one-cycle replay pulse, and the upstream stage re-sends the access with the expectation set. A strengthening input widens every fence so that it protects device and memory traffic alike.

Both request sides use valid/ready. `in_ready` depends on `out_ready` in the same cycle, and a fence or a late-override request is consumed without needing `out_ready`. A held access stays at the input until the gate accepts it. The response side has no ready signal: every response is taken in the cycle it is presented.

Top module: `io_order_gate`

## Requirements
- R1: An access is sorted by `in_op` (0 load, 1 store) and by its device attribute into class 0 device input (device load), class 1 device output (device store), class 2 memory read or class 3 memory write, and the class is shown on `out_class`. The device attribute is `in_io`, OR-ed with the page override when that applies.
- R2: Each class keeps an outstanding count. The count goes up by one on an accepted forward and down by one on a response of that class. When both happen in the same cycle the count does not change, and a response that arrives while the count is zero is ignored.
- R3: An access whose class count is at its maximum (2^CNT_W-1, which is 15 by default) is held until a response of that class arrives.
- R4: A fence (`in_op[1]`=1) carries predecessor and successor masks in which bit 0 is I, bit 1 is O, bit 2 is R and bit 3 is W, matching the class numbers. If every predecessor class count is already zero, the fence is consumed in one cycle and adds no stall.
- R5: Otherwise the fence stays pending, and accesses whose class is in the predecessor or successor mask are held until all predecessor class counts reach zero. Accesses of other classes pass, and a second fence waits.
- R6: When `strengthen` is high, a mask bit for I or R stands for both I and R, and a mask bit for O or W stands for both O and W.
- R7: When `virt_mode` and `in_pgovr` are both high and `in_hint` is high, the access is treated as a device access and forwarded with `out_acqrel`=1. It is sent only when every class count is zero, and no later access is sent until all counts are zero again.
- R8: When `virt_mode` is low, `in_pgovr` has no effect on the class, on `out_acqrel` or on replay.
- R9: An overridden access with `in_hint` low produces `replay`=1 for that cycle together with `in_ready`=1 and `out_valid`=0, and no count changes.
- R10: Channel 1 (point-to-point, `in_chan`=1) accesses to one device wait until the earlier channel-1 accesses to that same device have completed. Accesses to other devices are not held by them.
- R11: A channel 2 (global, `in_chan`=2) access waits until every earlier channel-2 access has completed.
- R12: `out_valid` is high only for an access at the input that is not held, `in_ready` for such an access follows `out_ready`, and the tag, channel and device pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| virt_mode | input | 1 | guest mode: enables the page override |
| strengthen | input | 1 | widens every fence mask |
| in_valid | input | 1 | request present |
| in_ready | output | 1 | request consumed |
| in_op | input | 2 | 0 load, 1 store, bit 1 set: fence |
| in_io | input | 1 | region attribute: device region |
| in_chan | input | 2 | 0 relaxed, 1 point-to-point, 2 global |
| in_dev | input | DEV_W | device number |
| in_pgovr | input | 1 | second-stage page override |
| in_hint | input | 1 | upstream already expects ordered handling |
| in_pred | input | 4 | fence predecessor mask |
| in_succ | input | 4 | fence successor mask |
| in_tag | input | TAG_W | request tag |
| out_valid | output | 1 | access forwarded |
| out_ready | input | 1 | interconnect accepts |
| out_class | output | 2 | ordering class |
| out_acqrel | output | 1 | acquire-plus-release access |
| out_chan | output | 2 | channel, passed through |
| out_dev | output | DEV_W | device, passed through |
| out_tag | output | TAG_W | tag, passed through |
| rsp_valid | input | 1 | completion from interconnect |
| rsp_class | input | 2 | class of the completed access |
| rsp_chan | input | 2 | channel of the completed access |
| rsp_dev | input | DEV_W | device of the completed access |
| replay | output | 1 | late override: re-send the access |

## Verification
The assertions check, on every cycle, that the class tracks the load or store kind, that counts move by at most one, that no forward happens into a full count, that an acquire-plus-release access leaves only when nothing is in flight and blocks the cycle after it, and that a replay consumes the request without forwarding it. Only the bench scenarios can show which accesses a given fence mask holds under each strengthening setting, the per-device and global channel serialization, that the count is unchanged after a replay and after a simultaneous issue and response, and that the override has no effect outside guest mode.

// File: rtl/iog_pkg.sv
`timescale 1ns/1ps
package iog_pkg;
  localparam int NCLS = 4;

  typedef enum logic [1:0] {
    CLS_DIN  = 2'd0,
    CLS_DOUT = 2'd1,
    CLS_MRD  = 2'd2,
    CLS_MWR  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    CH_RELAX  = 2'd0,
    CH_P2P    = 2'd1,
    CH_GLOBAL = 2'd2,
    CH_RSVD   = 2'd3
  } chan_e;

  // Widen a class mask: I and R merge, O and W merge.
  function automatic logic [NCLS-1:0] widen_set(input logic [NCLS-1:0] s);
    logic rd_side, wr_side;
    rd_side = s[CLS_DIN] | s[CLS_MRD];
    wr_side = s[CLS_DOUT] | s[CLS_MWR];
    return s | {wr_side, rd_side, wr_side, rd_side};
  endfunction
endpackage

// File: rtl/iog_classify.sv
`timescale 1ns/1ps
module iog_classify
  import iog_pkg::*;
(
  input  logic [1:0] op,
  input  logic       pma_io,
  input  logic       pg_ovr,
  input  logic       virt,
  input  logic       hint,
  output logic       is_acc,
  output logic       is_fence,
  output logic       late,
  output logic       acqrel,
  output logic [1:0] cls
);
  logic promote;
  logic dev_side;

  always_comb begin
    promote  = virt & pg_ovr;
    dev_side = pma_io | promote;
    is_fence = op[1];
    is_acc   = ~op[1];
    acqrel   = is_acc & promote & hint;
    late     = is_acc & promote & ~hint;
    if (op[0]) cls = dev_side ? CLS_DOUT : CLS_MWR;
    else       cls = dev_side ? CLS_DIN  : CLS_MRD;
  end
endmodule

// File: rtl/iog_counter.sv
`timescale 1ns/1ps
module iog_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero,
  output logic         full
);
  logic dec_ok;

  assign dec_ok = dec & (cnt != '0);
  assign zero   = (cnt == '0);
  assign full   = &cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case ({inc, dec_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/iog_fence_ctl.sv
`timescale 1ns/1ps
module iog_fence_ctl
  import iog_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            strengthen,
  input  logic [NCLS-1:0] pred_in,
  input  logic [NCLS-1:0] succ_in,
  input  logic [NCLS-1:0] cls_zero,
  output logic            busy,
  output logic [NCLS-1:0] blk
);
  logic            pend_q;
  logic [NCLS-1:0] pred_q;
  logic [NCLS-1:0] blk_q;
  logic [NCLS-1:0] pred_eff;
  logic [NCLS-1:0] succ_eff;
  logic            drained;
  logic            new_clear;

  always_comb begin
    pred_eff  = strengthen ? widen_set(pred_in) : pred_in;
    succ_eff  = strengthen ? widen_set(succ_in) : succ_in;
    drained   = &(cls_zero | ~pred_q);
    new_clear = &(cls_zero | ~pred_eff);
    busy      = pend_q & ~drained;
    blk       = blk_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pred_q <= '0;
      blk_q  <= '0;
    end else if (take && !new_clear) begin
      pend_q <= 1'b1;
      pred_q <= pred_eff;
      blk_q  <= pred_eff | succ_eff;
    end else if (pend_q && drained) begin
      pend_q <= 1'b0;
      pred_q <= '0;
      blk_q  <= '0;
    end
  end
endmodule

// File: rtl/io_order_gate.sv
`timescale 1ns/1ps
module io_order_gate
  import iog_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DEV_W = 2,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             virt_mode,
  input  logic             strengthen,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic             in_io,
  input  logic [1:0]       in_chan,
  input  logic [DEV_W-1:0] in_dev,
  input  logic             in_pgovr,
  input  logic             in_hint,
  input  logic [3:0]       in_pred,
  input  logic [3:0]       in_succ,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_class,
  output logic             out_acqrel,
  output logic [1:0]       out_chan,
  output logic [DEV_W-1:0] out_dev,
  output logic [TAG_W-1:0] out_tag,
  input  logic             rsp_valid,
  input  logic [1:0]       rsp_class,
  input  logic [1:0]       rsp_chan,
  input  logic [DEV_W-1:0] rsp_dev,
  output logic             replay
);
  localparam int NDEV = 1 << DEV_W;

  logic                       is_acc, is_fence, late, acqrel;
  logic [1:0]                 cls;
  logic [NCLS-1:0]            cls_zero, cls_full;
  logic [NCLS-1:0][CNT_W-1:0] cls_cnt;
  logic [NDEV-1:0]            p2p_zero, p2p_full;
  logic [NDEV-1:0][CNT_W-1:0] p2p_cnt;
  logic                       glob_zero, glob_full;
  logic [CNT_W-1:0]           glob_cnt;
  logic                       fence_busy;
  logic [NCLS-1:0]            fence_blk;
  logic                       all_zero;
  logic                       acq_hold_q, acq_busy;
  logic                       st_fence, st_acq, st_full, st_chan, stall;
  logic                       fire, fence_take;

  iog_classify u_cls (
    .op       (in_op),
    .pma_io   (in_io),
    .pg_ovr   (in_pgovr),
    .virt     (virt_mode),
    .hint     (in_hint),
    .is_acc   (is_acc),
    .is_fence (is_fence),
    .late     (late),
    .acqrel   (acqrel),
    .cls      (cls)
  );

  // Per-class outstanding counts.
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    iog_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (fire && (cls == c[1:0])),
      .dec   (rsp_valid && (rsp_class == c[1:0])),
      .cnt   (cls_cnt[c]),
      .zero  (cls_zero[c]),
      .full  (cls_full[c])
    );
  end

  // Point-to-point channel: one count per device.
  for (genvar d = 0; d < NDEV; d++) begin : g_p2p
    iog_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (fire && (in_chan == CH_P2P) && (in_dev == d[DEV_W-1:0])),
      .dec   (rsp_valid && (rsp_chan == CH_P2P) && (rsp_dev == d[DEV_W-1:0])),
      .cnt   (p2p_cnt[d]),
      .zero  (p2p_zero[d]),
      .full  (p2p_full[d])
    );
  end

  // Global channel: one shared count.
  iog_counter #(.W(CNT_W)) u_glob (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (fire && (in_chan == CH_GLOBAL)),
    .dec   (rsp_valid && (rsp_chan == CH_GLOBAL)),
    .cnt   (glob_cnt),
    .zero  (glob_zero),
    .full  (glob_full)
  );

  iog_fence_ctl u_fence (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (fence_take),
    .strengthen (strengthen),
    .pred_in    (in_pred),
    .succ_in    (in_succ),
    .cls_zero   (cls_zero),
    .busy       (fence_busy),
    .blk        (fence_blk)
  );

  always_comb begin
    all_zero = &cls_zero;
    acq_busy = acq_hold_q & ~all_zero;
    st_fence = fence_busy & fence_blk[cls];
    st_acq   = acq_busy | (acqrel & ~all_zero);
    st_full  = cls_full[cls];
    st_chan  = 1'b0;
    case (in_chan)
      CH_P2P:    st_chan = ~p2p_zero[in_dev] | p2p_full[in_dev];
      CH_GLOBAL: st_chan = ~glob_zero | glob_full;
      default:   st_chan = 1'b0;
    endcase
    stall = st_fence | st_acq | st_full | st_chan;
  end

  assign out_valid  = in_valid & is_acc & ~late & ~stall;
  assign fire       = out_valid & out_ready;
  assign fence_take = in_valid & is_fence & ~fence_busy;
  assign replay     = in_valid & late;
  assign in_ready   = is_fence ? ~fence_busy
                    : (late ? 1'b1 : (out_ready & ~stall));

  assign out_class  = cls;
  assign out_acqrel = acqrel;
  assign out_chan   = in_chan;
  assign out_dev    = in_dev;
  assign out_tag    = in_tag;

  always_ff @(posedge clk) begin
    if (!rst_n)               acq_hold_q <= 1'b0;
    else if (fire && acqrel)  acq_hold_q <= 1'b1;
    else if (all_zero)        acq_hold_q <= 1'b0;
  end
endmodule

// File: rtl/iog_checker.sv
`timescale 1ns/1ps
module iog_checker #(
  parameter int CNT_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [1:0]            in_op,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [1:0]            out_class,
  input logic                  out_acqrel,
  input logic                  replay,
  input logic [3:0][CNT_W-1:0] cls_cnt
);
  // R1: the class low bit follows load versus store.
  p_store_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_class[0] == in_op[0]));

  // R2: counts move by at most one per cycle.
  for (genvar c = 0; c < 4; c++) begin : g_step
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_cnt[c] == $past(cls_cnt[c])) ||
      (cls_cnt[c] == $past(cls_cnt[c]) + 1'b1) ||
      (cls_cnt[c] + 1'b1 == $past(cls_cnt[c])));
  end

  // R3: never forward into a full count.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (cls_cnt[out_class] != '1));

  // R7: ordered access leaves only with nothing in flight.
  p_acq_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_acqrel) |-> (cls_cnt == '0));

  // R7: nothing follows it in the next cycle.
  p_acq_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_acqrel) |=> !out_valid);

  // R9: replay consumes the request without forwarding.
  p_replay_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> (in_ready && !out_valid));

  // R12: forwards only an access presented at the input.
  p_fwd_from_input_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_valid && !in_op[1]));
endmodule

bind io_order_gate iog_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_class  (out_class),
  .out_acqrel (out_acqrel),
  .replay     (replay),
  .cls_cnt    (cls_cnt)
);

// File: tb/io_order_gate_test.sv
`timescale 1ns/1ps
module io_order_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       virt_mode = 1'b0, strengthen = 1'b0;
  logic       in_valid = 1'b0, in_ready;
  logic [1:0] in_op = 2'd0;
  logic       in_io = 1'b0;
  logic [1:0] in_chan = 2'd0;
  logic [1:0] in_dev = 2'd0;
  logic       in_pgovr = 1'b0, in_hint = 1'b0;
  logic [3:0] in_pred = 4'd0, in_succ = 4'd0;
  logic [3:0] in_tag = 4'd0;
  logic       out_valid, out_ready = 1'b1;
  logic [1:0] out_class;
  logic       out_acqrel;
  logic [1:0] out_chan;
  logic [1:0] out_dev;
  logic [3:0] out_tag;
  logic       rsp_valid = 1'b0;
  logic [1:0] rsp_class = 2'd0, rsp_chan = 2'd0, rsp_dev = 2'd0;
  logic       replay;

  int total = 0, fails = 0;
  bit done = 0;
  logic s_ov, s_ir, s_rp, s_aq;
  logic [1:0] s_cls;
  logic [3:0] s_tag;

  always #2 clk = ~clk;

  io_order_gate uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drv(input logic [1:0] op, input logic io, input logic [1:0] ch,
                     input logic [1:0] dev, input logic ovr, input logic hint,
                     input logic [3:0] pred, input logic [3:0] succ,
                     input logic [3:0] tag);
    @(negedge clk);
    in_op = op; in_io = io; in_chan = ch; in_dev = dev; in_pgovr = ovr;
    in_hint = hint; in_pred = pred; in_succ = succ; in_tag = tag; in_valid = 1'b1;
    #1;
    s_ov = out_valid; s_ir = in_ready; s_rp = replay; s_aq = out_acqrel;
    s_cls = out_class; s_tag = out_tag;
    @(posedge clk); #1;
    in_valid = 1'b0; rsp_valid = 1'b0;
  endtask

  task automatic acc(input int j, input logic [1:0] ch, input logic [1:0] dev);
    drv({1'b0, j[0]}, ~j[1], ch, dev, 1'b0, 1'b1, 4'd0, 4'd0, 4'd0);
  endtask

  task automatic rsp(input int j, input logic [1:0] ch, input logic [1:0] dev);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_class = j[1:0]; rsp_chan = ch; rsp_dev = dev;
    @(posedge clk); #1;
    rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset out_valid", out_valid, 0);
    chk("R9 reset replay", replay, 0);
    rst_n = 1'b1;

    // R1 R7 R8: classification sweep over kind, attribute, override, mode.
    for (int v = 0; v < 2; v++) begin
      for (int op = 0; op < 2; op++) begin
        for (int io = 0; io < 2; io++) begin
          for (int ov = 0; ov < 2; ov++) begin
            int dv, ec;
            virt_mode = v[0];
            drv(op[1:0], io[0], 2'd0, 2'd0, ov[0], 1'b1, 4'd0, 4'd0, 4'd3);
            dv = io | (v & ov);
            ec = op ? (dv ? 1 : 3) : (dv ? 0 : 2);
            chk("R12 forwarded", s_ov, 1);
            chk(v ? "R1 class" : "R8 class", s_cls, ec);
            chk(v ? "R7 acqrel flag" : "R8 acqrel flag", s_aq, v & ov);
            rsp(ec, 2'd0, 2'd0);
          end
        end
      end
    end

    // R9: late override replays; counts unchanged afterwards.
    virt_mode = 1'b1;
    drv(2'd0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0);
    chk("R9 replay", s_rp, 1);
    chk("R9 no forward", s_ov, 0);
    chk("R9 consumed", s_ir, 1);
    drv(2'd0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 4'd0, 4'd0, 4'd0);
    chk("R9 pulse ends", s_rp, 0);
    chk("R9 not counted twice", s_ov, 1);
    rsp(0, 2'd0, 2'd0);
    virt_mode = 1'b0;
    drv(2'd0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0);
    chk("R8 no replay outside mode", s_rp, 0);
    chk("R8 class outside mode", s_cls, 2);
    rsp(2, 2'd0, 2'd0);

    // R7: ordered access waits for drain and blocks followers.
    virt_mode = 1'b1;
    acc(2, 2'd0, 2'd0);
    drv(2'd0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 4'd0, 4'd0, 4'd0);
    chk("R7 waits for in-flight", s_ov, 0);
    rsp(2, 2'd0, 2'd0);
    drv(2'd0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 4'd0, 4'd0, 4'd0);
    chk("R7 sent when drained", s_ov, 1);
    acc(3, 2'd0, 2'd0);
    chk("R7 follower held", s_ov, 0);
    rsp(0, 2'd0, 2'd0);
    acc(3, 2'd0, 2'd0);
    chk("R7 follower released", s_ov, 1);
    rsp(3, 2'd0, 2'd0);
    virt_mode = 1'b0;

    // R4 R5 R6: fence mask sweep, both strengthening settings.
    for (int s = 0; s < 2; s++) begin
      strengthen = s[0];
      for (int j = 0; j < 4; j++) begin
        for (int p = 0; p < 16; p++) begin
          logic [3:0] e;
          logic ir, ow;
          acc(j, 2'd0, 2'd0);
          drv(2'd2, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, p[3:0], 4'hF, 4'd0);
          chk("R4 fence accepted", s_ir, 1);
          ir = p[0] | p[2];
          ow = p[1] | p[3];
          e = s ? (p[3:0] | {ow, ir, ow, ir}) : p[3:0];
          acc(j, 2'd0, 2'd0);
          chk(s ? "R6 strengthened hold" : "R5 fence hold", s_ov, !e[j]);
          rsp(j, 2'd0, 2'd0);
          if (s_ov) rsp(j, 2'd0, 2'd0);
        end
      end
    end
    strengthen = 1'b0;

    // R5: classes outside both masks pass a pending fence.
    acc(2, 2'd0, 2'd0);
    drv(2'd2, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'b0100, 4'b1000, 4'd0);
    acc(0, 2'd0, 2'd0);
    chk("R5 unrelated class passes", s_ov, 1);
    acc(3, 2'd0, 2'd0);
    chk("R5 successor held", s_ov, 0);
    rsp(2, 2'd0, 2'd0);
    acc(3, 2'd0, 2'd0);
    chk("R5 successor released", s_ov, 1);
    rsp(0, 2'd0, 2'd0);
    rsp(3, 2'd0, 2'd0);

    // R2 R3: fill class 3, simultaneous issue and response.
    for (int k = 0; k < 14; k++) acc(3, 2'd0, 2'd0);
    rsp_valid = 1'b1; rsp_class = 2'd3; rsp_chan = 2'd0;
    acc(3, 2'd0, 2'd0);
    chk("R2 simultaneous issue", s_ov, 1);
    acc(3, 2'd0, 2'd0);
    chk("R2 count unchanged by simultaneous", s_ov, 1);
    acc(3, 2'd0, 2'd0);
    chk("R3 full count holds", s_ov, 0);
    rsp(3, 2'd0, 2'd0);
    acc(3, 2'd0, 2'd0);
    chk("R3 released after response", s_ov, 1);
    for (int k = 0; k < 15; k++) rsp(3, 2'd0, 2'd0);
    acc(3, 2'd0, 2'd0);
    chk("R2 drained", s_ov, 1);
    rsp(3, 2'd0, 2'd0);

    // R10: point-to-point per device.
    acc(0, 2'd1, 2'd1);
    chk("R10 first issue", s_ov, 1);
    acc(0, 2'd1, 2'd1);
    chk("R10 same device held", s_ov, 0);
    acc(0, 2'd1, 2'd2);
    chk("R10 other device passes", s_ov, 1);
    rsp(0, 2'd1, 2'd1);
    acc(0, 2'd1, 2'd1);
    chk("R10 same device released", s_ov, 1);
    rsp(0, 2'd1, 2'd1);
    rsp(0, 2'd1, 2'd2);

    // R11: global channel.
    acc(1, 2'd2, 2'd0);
    chk("R11 first issue", s_ov, 1);
    acc(1, 2'd2, 2'd3);
    chk("R11 any device held", s_ov, 0);
    rsp(1, 2'd2, 2'd0);
    acc(1, 2'd2, 2'd3);
    chk("R11 released", s_ov, 1);
    rsp(1, 2'd2, 2'd3);

    // R12: back-pressure and pass-through.
    out_ready = 1'b0;
    drv(2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd5);
    chk("R12 valid under back-pressure", s_ov, 1);
    chk("R12 ready follows out_ready", s_ir, 0);
    out_ready = 1'b1;
    drv(2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd9);
    chk("R12 tag passes", s_tag, 9);
    chk("R12 accepted", s_ir, 1);
    rsp(2, 2'd0, 2'd0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule